// File: doc/BRIEF.md
# Windowed Watchdog with Status Word

This block supervises software liveness with a windowed watchdog. A base timebase delivers single-cycle ticks; the watchdog counts them over a period equal to a base tick count times a programmable divider. In windowed operation the first half of each period is a closed window, in which a refresh is treated as a fault, and the second half is an open window, in which a refresh restarts the period. If the period runs out, or if a refresh lands in the closed window, the block emits a one-cycle reset request for the system reset generator.

Configuration arrives as a 4-bit timing-control write. Its top bit chooses whether the low three bits program the watchdog divider or the cyclic-sense interval code, which is passed on to the neighbouring sensing block. Every timing-control write, and every status read, captures a 4-bit status word on the status output. A sticky timeout flag records that the most recent reset request came from the watchdog. The reset request does not clear this flag, so the flag survives the reset it caused. The access that returns the flag also clears it.

Top module: `wdog_window_top`

## Requirements
- R1: On a write with data bit 3 = 0, bits 2:0 become the watchdog divider code. On a write with bit 3 = 1, bits 2:0 appear on `cyc_code_o` from the next cycle, and the watchdog divider code is left unchanged.
- R2: Divider codes 0..7 select dividers 1, 2, 4, 6, 8, 10, 12, 14. In windowed operation the period is BASE_TICKS × divider ticks.
- R3: In windowed operation, after a restart the window is closed while fewer than period/2 ticks have been counted and open from then on. Status bit 0 reports the open window.
- R4: A refresh in the open window restarts the period and raises no reset request.
- R5: A refresh in the closed window raises `rst_req_o` for exactly the following cycle, sets the timeout flag and the error flag, and restarts the period.
- R6: When the tick that completes the period arrives with no refresh, `rst_req_o` goes high for the following cycle, the timeout flag is set, the error flag is cleared, and the period restarts.
- R7: With `win_en_i` = 0 the window is always open and the period is BASE_TICKS ticks, whatever the divider code.
- R8: With `wd_en_i` = 0 the count is held at zero and ticks and refreshes have no effect. The status word reads watchdog-off = 1 and window-open = 0.
- R9: Status bit order is bit 3 timeout, bit 2 error, bit 1 watchdog-off, bit 0 window-open. A write or read strobe loads it into `status_o` in the next cycle, and `status_o` holds that value until the next strobe.
- R10: A write or read clears the timeout and error flags after they are captured. A fault event in the same cycle as the access takes priority, so its flag stays set.
- R11: After the synchronous power-on reset, `status_o` = 0, `rst_req_o` = 0, `cyc_code_o` = 0, both flags are 0, and the divider code is 000 (period BASE_TICKS).
- R12: The timeout flag stays set across the reset request and any idle time until an access or power-on reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | One-cycle timebase tick |
| wr_i | input | 1 | Timing-control write strobe |
| wr_data_i | input | 4 | Timing-control write data (bit 3 select, bits 2:0 code) |
| rd_i | input | 1 | Status read strobe |
| refresh_i | input | 1 | Watchdog refresh strobe |
| win_en_i | input | 1 | Windowed operation enable |
| wd_en_i | input | 1 | Watchdog enable |
| rst_req_o | output | 1 | One-cycle reset request |
| status_o | output | 4 | Captured status word |
| cyc_code_o | output | 3 | Cyclic-sense interval code |

## Verification
The bench sweeps all eight divider codes and, for each one, probes the tick just before the window opens, the tick where it opens, and the last tick of the period. An off-by-one in the half-period compare would let early refreshes through or punish legal ones, and a wrong divider step would move the expiry tick. It fires a refresh in the same cycle as a status read to catch a design that lets the clear win over a new fault and so loses a timeout. It also routes a write to the cyclic-sense code to expose a design that corrupts the watchdog divider. Disabled and non-windowed runs catch a counter that keeps running, or a prescaler that leaks through, when it should not.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Status word, bit 3 down to bit 0
    typedef struct packed {
        logic timeout;
        logic error;
        logic off;
        logic win_open;
    } wd_status_t;

    // Timing-control write layout
    typedef struct packed {
        logic       sel_cyc;
        logic [2:0] code;
    } tim_wr_t;

    // Fault events produced by the timer in the current cycle
    typedef struct packed {
        logic early;
        logic expire;
    } wd_event_t;

    localparam int CODE_W = 3;
    localparam int MAX_DIV = 14;

    // Even-step divider: 0 -> 1, otherwise 2 * code
    function automatic int div_of(input logic [CODE_W-1:0] code);
        if (code == '0) return 1;
        return 2 * int'(code);
    endfunction

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  tim_wr_t           wr_data_i,
    output logic [CODE_W-1:0] wd_code_o,
    output logic [CODE_W-1:0] cyc_code_o
);

    // R1, R11: select bit routes the code to one of two write-only registers
    always_ff @(posedge clk) begin
        if (rst) begin
            wd_code_o  <= '0;
            cyc_code_o <= '0;
        end else if (wr_i) begin
            if (wr_data_i.sel_cyc) cyc_code_o <= wr_data_i.code;
            else                   wd_code_o  <= wr_data_i.code;
        end
    end

    // R1: a cyclic-sense write leaves the watchdog code alone
    a_r1_cyc_keeps_wd: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wr_data_i.sel_cyc) |=> $stable(wd_code_o));

endmodule

// File: rtl/wdog_window_timer.sv
module wdog_window_timer
    import wdog_pkg::*;
#(
    parameter int BASE_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              refresh_i,
    input  logic              wd_en_i,
    input  logic              win_en_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              win_open_o,
    output wd_event_t         evt_o,
    output logic              rst_req_o
);

    localparam int CNT_W = $clog2(BASE_TICKS * MAX_DIV + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half;
    logic             last_tick;

    // R2, R7: divider applies only in windowed operation
    always_comb begin
        if (win_en_i) period = CNT_W'(BASE_TICKS * div_of(code_i));
        else          period = CNT_W'(BASE_TICKS);
        half = period >> 1;
    end

    // R3, R7, R8: window phase
    assign win_open_o = wd_en_i && (!win_en_i || (cnt_q >= half));
    assign last_tick  = (cnt_q >= period - CNT_W'(1));

    // R5, R6: fault events, refresh has priority over a tick
    always_comb begin
        evt_o.early  = wd_en_i && refresh_i && !win_open_o;
        evt_o.expire = wd_en_i && !refresh_i && tick_i && last_tick;
    end

    always_ff @(posedge clk) begin
        if (rst || !wd_en_i) begin
            cnt_q     <= '0;
            rst_req_o <= 1'b0;
        end else begin
            rst_req_o <= evt_o.early || evt_o.expire;
            if (refresh_i)            cnt_q <= '0;
            else if (tick_i) begin
                if (last_tick)        cnt_q <= '0;
                else                  cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    a_r5_early_req: assert property (@(posedge clk) disable iff (rst)
        evt_o.early |=> rst_req_o);
    a_r6_expire_req: assert property (@(posedge clk) disable iff (rst)
        evt_o.expire |=> rst_req_o);
    a_r4_open_refresh: assert property (@(posedge clk) disable iff (rst)
        (wd_en_i && refresh_i && win_open_o) |=> !rst_req_o);
    a_r8_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !wd_en_i |=> !rst_req_o);

endmodule

// File: rtl/wdog_status.sv
module wdog_status
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       access_i,
    input  wd_event_t  evt_i,
    input  logic       off_i,
    input  logic       win_open_i,
    output wd_status_t status_o
);

    logic to_q;
    logic err_q;

    // R9: snapshot on every write or read
    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
        end else if (access_i) begin
            status_o.timeout  <= to_q;
            status_o.error    <= err_q;
            status_o.off      <= off_i;
            status_o.win_open <= win_open_i;
        end
    end

    // R10, R12: sticky flags, new events beat the clear-on-access
    always_ff @(posedge clk) begin
        if (rst) begin
            to_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (evt_i.early || evt_i.expire) to_q <= 1'b1;
            else if (access_i)               to_q <= 1'b0;

            if (evt_i.early)                 err_q <= 1'b1;
            else if (evt_i.expire)           err_q <= 1'b0;
            else if (access_i)               err_q <= 1'b0;
        end
    end

    a_r10_clear_on_access: assert property (@(posedge clk) disable iff (rst)
        (access_i && !evt_i.early && !evt_i.expire) |=> !to_q);
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (to_q && !access_i) |=> to_q);
    a_r5_early_flags: assert property (@(posedge clk) disable iff (rst)
        evt_i.early |=> (to_q && err_q));

endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
    import wdog_pkg::*;
#(
    parameter int BASE_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       wr_i,
    input  logic [3:0] wr_data_i,
    input  logic       rd_i,
    input  logic       refresh_i,
    input  logic       win_en_i,
    input  logic       wd_en_i,
    output logic       rst_req_o,
    output logic [3:0] status_o,
    output logic [2:0] cyc_code_o
);

    logic [CODE_W-1:0] wd_code;
    logic              win_open;
    wd_event_t         evt;
    wd_status_t        status;

    wdog_cfg_reg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr_i),
        .wr_data_i  (tim_wr_t'(wr_data_i)),
        .wd_code_o  (wd_code),
        .cyc_code_o (cyc_code_o)
    );

    wdog_window_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .refresh_i  (refresh_i),
        .wd_en_i    (wd_en_i),
        .win_en_i   (win_en_i),
        .code_i     (wd_code),
        .win_open_o (win_open),
        .evt_o      (evt),
        .rst_req_o  (rst_req_o)
    );

    wdog_status u_status (
        .clk        (clk),
        .rst        (rst),
        .access_i   (wr_i || rd_i),
        .evt_i      (evt),
        .off_i      (!wd_en_i),
        .win_open_i (win_open),
        .status_o   (status)
    );

    assign status_o = status;

endmodule

// File: tb/wdog_window_top_bench.sv
module wdog_window_top_bench;

    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, refresh_i = 1'b0;
    logic [3:0] wr_data_i = '0;
    logic       win_en_i = 1'b1, wd_en_i = 1'b1;
    logic       rst_req_o;
    logic [3:0] status_o;
    logic [2:0] cyc_code_o;

    int checks = 0, fails = 0, nreq = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_window_top #(.BASE_TICKS(BASE)) u_wdog_window_top (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_i(wr_i), .wr_data_i(wr_data_i),
        .rd_i(rd_i), .refresh_i(refresh_i), .win_en_i(win_en_i), .wd_en_i(wd_en_i),
        .rst_req_o(rst_req_o), .status_o(status_o), .cyc_code_o(cyc_code_o)
    );

    always @(negedge clk) if (rst_req_o) nreq++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
        #1;
    endtask

    task automatic refresh();
        @(negedge clk) refresh_i = 1'b1;
        @(negedge clk) refresh_i = 1'b0;
        #1;
    endtask

    task automatic do_read();
        @(negedge clk) rd_i = 1'b1;
        @(negedge clk) rd_i = 1'b0;
        #1;
    endtask

    task automatic do_write(input logic [3:0] d);
        @(negedge clk) begin wr_i = 1'b1; wr_data_i = d; end
        @(negedge clk) wr_i = 1'b0;
        #1;
    endtask

    task automatic restart();
        @(negedge clk) wd_en_i = 1'b0;
        @(negedge clk) wd_en_i = 1'b1;
        #1;
    endtask

    function automatic int exp_div(input int c);
        return (c == 0) ? 1 : 2 * c;
    endfunction

    initial begin
        int p, h, r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        chk("R11 status", status_o, 0);
        chk("R11 req", rst_req_o, 0);
        chk("R11 cyc", cyc_code_o, 0);
        do_read();
        chk("R11 flags", status_o, 4'b0000);
        r0 = nreq;
        ticks(BASE - 1);
        chk("R11 default period no req", nreq, r0);
        ticks(1);
        chk("R11 default period req", nreq, r0 + 1);
        do_read();
        chk("R6 timeout after expiry", status_o, 4'b1000);

        // R2..R6 sweep over all divider codes
        for (int c = 0; c < 8; c++) begin
            p = BASE * exp_div(c);
            h = p / 2;
            do_write({1'b0, 3'(c)});
            restart();
            r0 = nreq;
            ticks(p - 1);
            chk($sformatf("R2 code%0d no early req", c), nreq, r0);
            do_read();
            chk($sformatf("R3 code%0d open late", c), status_o, 4'b0001);
            ticks(1);
            chk($sformatf("R2 R6 code%0d expiry", c), nreq, r0 + 1);
            do_read();
            chk($sformatf("R6 code%0d flags", c), status_o, 4'b1000);
            // closed window
            ticks(h - 1);
            do_read();
            chk($sformatf("R3 code%0d closed", c), status_o, 4'b0000);
            r0 = nreq;
            refresh();
            chk($sformatf("R5 code%0d early req", c), nreq, r0 + 1);
            do_read();
            chk($sformatf("R5 code%0d flags", c), status_o, 4'b1100);
            // open window refresh
            ticks(h);
            do_read();
            chk($sformatf("R3 code%0d opens at half", c), status_o, 4'b0001);
            r0 = nreq;
            refresh();
            chk($sformatf("R4 code%0d no req", c), nreq, r0);
            ticks(p - 1);
            chk($sformatf("R4 code%0d restarted", c), nreq, r0);
            ticks(1);
            chk($sformatf("R4 code%0d expiry after restart", c), nreq, r0 + 1);
        end

        // R1: cyclic write keeps the watchdog code (code 2 -> period 4*BASE)
        do_write(4'b0_010);
        do_write(4'b1_101);
        chk("R1 cyc code", cyc_code_o, 5);
        restart();
        r0 = nreq;
        ticks(4 * BASE - 1);
        chk("R1 wd period kept", nreq, r0);
        ticks(1);
        chk("R1 wd period expiry", nreq, r0 + 1);

        // R12: flag survives idle time; R9/R10 write returns status then clears
        repeat (20) @(negedge clk);
        do_write(4'b1_011);
        chk("R12 R9 write returns timeout", status_o[3], 1);
        chk("R1 cyc code update", cyc_code_o, 3);
        do_read();
        chk("R10 cleared by write", status_o[3], 0);

        // R10: fault in same cycle as read wins
        restart();
        @(negedge clk) begin refresh_i = 1'b1; rd_i = 1'b1; end
        @(negedge clk) begin refresh_i = 1'b0; rd_i = 1'b0; end
        #1;
        chk("R10 snapshot before event", status_o[3], 0);
        do_read();
        chk("R10 event beats clear", status_o, 4'b1100);

        // R7: non-windowed, divider ignored
        do_write(4'b0_111);
        win_en_i = 1'b0;
        restart();
        do_read();
        chk("R7 always open", status_o, 4'b0001);
        r0 = nreq;
        refresh();
        chk("R7 refresh at zero ok", nreq, r0);
        ticks(BASE - 1);
        chk("R7 no req", nreq, r0);
        ticks(1);
        chk("R7 base period", nreq, r0 + 1);
        win_en_i = 1'b1;

        // R8: disabled
        do_read();
        @(negedge clk) wd_en_i = 1'b0;
        r0 = nreq;
        ticks(200);
        refresh();
        chk("R8 no req", nreq, r0);
        do_read();
        chk("R8 status", status_o, 4'b0010);
        @(negedge clk) wd_en_i = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule